// File: doc/BRIEF.md
# Guest Mode Virtualization Fault Logic

This block keeps the single bit that says whether a guest is running on the core and applies what that bit implies. While the bit is set, the block watches a pre-decoded instruction stream and the virtual address of every data access. It raises a virtualization fault for privileged work and for the hash-address lookup instruction, and an address exception when the guest touches the topmost implemented virtual-address bit, which stays reserved for the monitor. When the bit is clear, the core runs as if no virtualization support existed.

The mode bit is cleared by every interruption the core delivers and by every event this block raises, since each of these hands control to the monitor. Software sets the bit again either through a return-from-interruption issued in monitor mode, which restores a saved value, or through a dedicated switch instruction that writes the bit directly in either mode. The block also holds one pending virtual interrupt. When a guest performs an unmasking operation while one is pending, the block redirects control to the virtual external interrupt vector and reports the pending interrupt number.

All outputs are registered and respond on the clock edge that samples the stimulus. The cause code is held until the next event. The faulting opcode is held until the next virtualization fault.

Top module: `gmv_fault_top`

## Requirements
- R1: After reset the mode bit, all three strobes, the cause code, the captured opcode and the redirect number are 0, and no virtual interrupt is pending.
- R2: With the mode bit at 0, no instruction class and no access address raises any strobe. This includes accesses with bit VA_WIDTH-1 set.
- R3: With the mode bit at 1, a valid instruction of class 1 (privileged) or class 3 (return-from-interruption) pulses `virt_fault` for one cycle, with `fault_cause` = 1, on the edge that samples it.
- R4: With the mode bit at 1, a valid instruction of class 2 (hash-address lookup) pulses `virt_fault` with `fault_cause` = 2.
- R5: With the mode bit at 1, a data access whose address has bit VA_WIDTH-1 set pulses `addr_fault` with `fault_cause` = 3. The same access with that bit clear raises nothing.
- R6: `fault_opc` takes the opcode of the instruction that raised a virtualization fault and holds it through later cycles and other event kinds, until the next virtualization fault.
- R7: An interruption delivery (`intr_take`) clears the mode bit and suppresses every strobe in the cycle it is sampled.
- R8: Every raised strobe clears the mode bit on the same edge. Strobes are mutually exclusive and last one cycle.
- R9: Class 4 (mode switch) loads `sw_mode` into the mode bit in either mode without a fault. Class 3 in mode 0 loads `ret_mode` into the mode bit.
- R10: `vint_post` marks a virtual interrupt pending with number `vint_num`; a later post overwrites the number. In mode 1, a class 5 (unmask) instruction while one is pending pulses `vint_redirect` with `fault_cause` = 4 and `redirect_num` equal to the pending number, and clears the pending state. Class 5 with nothing pending, or in mode 0, raises nothing and leaves any pending interrupt intact.
- R11: An instruction event takes priority over an address exception raised in the same cycle. A post that arrives in the same cycle as a redirect leaves the newly posted interrupt pending.
- R12: Class 0 (plain) never raises a strobe in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | An instruction is issued this cycle |
| instr_cls | input | 3 | Pre-decoded class: 0 plain, 1 privileged, 2 hash lookup, 3 return-from-interruption, 4 mode switch, 5 unmask |
| instr_opc | input | OPC_W | Opcode of the issued instruction |
| ret_mode | input | 1 | Saved mode value restored by a return-from-interruption |
| sw_mode | input | 1 | Mode value written by the switch instruction |
| mem_valid | input | 1 | A data access is made this cycle |
| mem_va | input | VA_WIDTH | Virtual address of the access |
| intr_take | input | 1 | An interruption is delivered through the vector table |
| vint_post | input | 1 | Register a pending virtual interrupt |
| vint_num | input | VINT_W | Number of the posted virtual interrupt |
| guest_mode | output | 1 | Current mode bit |
| virt_fault | output | 1 | Virtualization fault pulse |
| addr_fault | output | 1 | Reserved address bit exception pulse |
| vint_redirect | output | 1 | Redirect to the virtual external interrupt vector |
| fault_cause | output | 3 | Cause of the last event: 1 privileged, 2 hash, 3 address, 4 redirect |
| fault_opc | output | OPC_W | Opcode of the last faulting instruction |
| redirect_num | output | VINT_W | Interrupt number of the last redirect |

## Verification
Each instruction class and each address pattern runs in both modes. Pairing them shows that the mode bit, and not the class alone, decides whether a fault is raised. Collisions in the same cycle are driven on purpose: an interruption with a faulting instruction, an instruction fault with a reserved-bit access, and a post with a redirect. These show the priority order and which post survives. A long mixed stream of classes, addresses, interruptions and posts then catches mode-bit bookkeeping errors that build up over many transitions. Held values, such as the opcode surviving an address exception, are compared on every cycle.

// File: rtl/gmv_pkg.sv
package gmv_pkg;

   typedef enum logic [2:0] {
      CLS_PLAIN  = 3'd0,
      CLS_PRIV   = 3'd1,
      CLS_HASH   = 3'd2,
      CLS_RET    = 3'd3,
      CLS_SWITCH = 3'd4,
      CLS_UNMASK = 3'd5
   } ins_cls_e;

   typedef enum logic [2:0] {
      CAUSE_NONE = 3'd0,
      CAUSE_PRIV = 3'd1,
      CAUSE_HASH = 3'd2,
      CAUSE_ADDR = 3'd3,
      CAUSE_VIRQ = 3'd4
   } cause_e;

endpackage

// File: rtl/gmv_classify.sv
module gmv_classify #(
   parameter int VA_WIDTH   = 51,
   parameter bit ADDR_GUARD = 1'b1
) (
   input  logic                   mode_i,
   input  logic                   intr_i,
   input  logic                   ins_valid_i,
   input  gmv_pkg::ins_cls_e      cls_i,
   input  logic                   mem_valid_i,
   input  logic [VA_WIDTH-1:0]    va_i,
   input  logic                   pend_i,
   output logic                   ins_fault_o,
   output logic                   redir_o,
   output logic                   aexc_o,
   output gmv_pkg::cause_e        cause_o
);
   import gmv_pkg::*;

   localparam int TOP_BIT = VA_WIDTH - 1;

   logic armed;
   logic reserved_hit;

   assign armed = mode_i & ~intr_i;

   generate
      if (ADDR_GUARD) begin : g_guard
         assign reserved_hit = mem_valid_i & va_i[TOP_BIT];
      end else begin : g_noguard
         logic unused_addr;
         assign unused_addr  = ^{mem_valid_i, va_i};
         assign reserved_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      ins_fault_o = 1'b0;
      redir_o     = 1'b0;
      cause_o     = CAUSE_NONE;
      if (armed && ins_valid_i) begin
         unique case (cls_i)
            CLS_PRIV, CLS_RET: begin
               ins_fault_o = 1'b1;
               cause_o     = CAUSE_PRIV;
            end
            CLS_HASH: begin
               ins_fault_o = 1'b1;
               cause_o     = CAUSE_HASH;
            end
            CLS_UNMASK: begin
               redir_o = pend_i;
               cause_o = pend_i ? CAUSE_VIRQ : CAUSE_NONE;
            end
            default: ;
         endcase
      end
      aexc_o = armed & reserved_hit & ~ins_fault_o & ~redir_o;
      if (aexc_o) begin
         cause_o = CAUSE_ADDR;
      end
   end

endmodule

// File: rtl/gmv_mode_reg.sv
module gmv_mode_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic kill_i,
   input  logic sw_i,
   input  logic sw_val_i,
   input  logic ret_i,
   input  logic ret_val_i,
   output logic mode_o
);

   logic mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
      end else if (kill_i) begin
         mode_q <= 1'b0;
      end else if (sw_i) begin
         mode_q <= sw_val_i;
      end else if (ret_i && !mode_q) begin
         mode_q <= ret_val_i;
      end
   end

   assign mode_o = mode_q;

   // R7
   kill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill_i |=> !mode_o);

   // R9
   switch_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_i && !kill_i) |=> (mode_o == $past(sw_val_i)));

endmodule

// File: rtl/gmv_vint_pend.sv
module gmv_vint_pend #(
   parameter int VINT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              post_i,
   input  logic [VINT_W-1:0] num_i,
   input  logic              take_i,
   output logic              pend_o,
   output logic [VINT_W-1:0] num_o
);

   logic              pend_q;
   logic [VINT_W-1:0] num_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         num_q  <= '0;
      end else if (post_i) begin
         pend_q <= 1'b1;
         num_q  <= num_i;
      end else if (take_i) begin
         pend_q <= 1'b0;
      end
   end

   assign pend_o = pend_q;
   assign num_o  = num_q;

   // R10
   take_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !post_i) |=> !pend_o);

   // R11
   post_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
      post_i |=> (pend_o && num_o == $past(num_i)));

endmodule

// File: rtl/gmv_fault_top.sv
module gmv_fault_top #(
   parameter int VA_WIDTH   = 51,
   parameter int OPC_W      = 41,
   parameter int VINT_W     = 8,
   parameter bit ADDR_GUARD = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                instr_valid,
   input  logic [2:0]          instr_cls,
   input  logic [OPC_W-1:0]    instr_opc,
   input  logic                ret_mode,
   input  logic                sw_mode,
   input  logic                mem_valid,
   input  logic [VA_WIDTH-1:0] mem_va,
   input  logic                intr_take,
   input  logic                vint_post,
   input  logic [VINT_W-1:0]   vint_num,
   output logic                guest_mode,
   output logic                virt_fault,
   output logic                addr_fault,
   output logic                vint_redirect,
   output logic [2:0]          fault_cause,
   output logic [OPC_W-1:0]    fault_opc,
   output logic [VINT_W-1:0]   redirect_num
);
   import gmv_pkg::*;

   initial begin
      va_width_ok: assert (VA_WIDTH >= 2 && VA_WIDTH <= 64)
         else $error("VA_WIDTH out of range");
      opc_width_ok: assert (OPC_W >= 1)
         else $error("OPC_W must be positive");
      vint_width_ok: assert (VINT_W >= 1 && VINT_W <= 16)
         else $error("VINT_W out of range");
   end

   ins_cls_e          cls;
   logic              mode;
   logic              ins_fault, redir, aexc, any_event;
   cause_e            cause;
   logic              pend;
   logic [VINT_W-1:0] pend_num;

   logic              vf_q, af_q, rd_q;
   logic [2:0]        cause_q;
   logic [OPC_W-1:0]  opc_q;
   logic [VINT_W-1:0] rnum_q;

   assign cls       = ins_cls_e'(instr_cls);
   assign any_event = ins_fault | redir | aexc;

   gmv_classify #(
      .VA_WIDTH   (VA_WIDTH),
      .ADDR_GUARD (ADDR_GUARD)
   ) u_classify (
      .mode_i      (mode),
      .intr_i      (intr_take),
      .ins_valid_i (instr_valid),
      .cls_i       (cls),
      .mem_valid_i (mem_valid),
      .va_i        (mem_va),
      .pend_i      (pend),
      .ins_fault_o (ins_fault),
      .redir_o     (redir),
      .aexc_o      (aexc),
      .cause_o     (cause)
   );

   gmv_mode_reg u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .kill_i    (intr_take | any_event),
      .sw_i      (instr_valid && cls == CLS_SWITCH),
      .sw_val_i  (sw_mode),
      .ret_i     (instr_valid && cls == CLS_RET),
      .ret_val_i (ret_mode),
      .mode_o    (mode)
   );

   gmv_vint_pend #(
      .VINT_W (VINT_W)
   ) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .post_i (vint_post),
      .num_i  (vint_num),
      .take_i (redir),
      .pend_o (pend),
      .num_o  (pend_num)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vf_q    <= 1'b0;
         af_q    <= 1'b0;
         rd_q    <= 1'b0;
         cause_q <= '0;
         opc_q   <= '0;
         rnum_q  <= '0;
      end else begin
         vf_q <= ins_fault;
         af_q <= aexc;
         rd_q <= redir;
         if (any_event) begin
            cause_q <= cause;
         end
         if (ins_fault) begin
            opc_q <= instr_opc;
         end
         if (redir) begin
            rnum_q <= pend_num;
         end
      end
   end

   assign guest_mode    = mode;
   assign virt_fault    = vf_q;
   assign addr_fault    = af_q;
   assign vint_redirect = rd_q;
   assign fault_cause   = cause_q;
   assign fault_opc     = opc_q;
   assign redirect_num  = rnum_q;

   // R8
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({virt_fault, addr_fault, vint_redirect}));

   // R8
   event_exits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (virt_fault || addr_fault || vint_redirect) |-> !guest_mode);

   // R2
   host_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !guest_mode |=> !(virt_fault || addr_fault || vint_redirect));

   // R7
   intr_mutes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      intr_take |=> !(virt_fault || addr_fault || vint_redirect));

   // R10
   redirect_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vint_redirect |-> (fault_cause == 3'd4));

   // R5
   addr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_fault |-> (fault_cause == 3'd3));

   // R3
   fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      virt_fault |-> (fault_cause == 3'd1 || fault_cause == 3'd2));

   // R6
   opc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !virt_fault |=> (virt_fault || $stable(fault_opc)));

endmodule

// File: tb/gmv_fault_top_tb.sv
module gmv_fault_top_tb;

   localparam int CLK_PERIOD = 10;
   localparam int VA   = 51;
   localparam int OPCW = 41;
   localparam int VW   = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            instr_valid = 1'b0;
   logic [2:0]      instr_cls = '0;
   logic [OPCW-1:0] instr_opc = '0;
   logic            ret_mode = 1'b0;
   logic            sw_mode = 1'b0;
   logic            mem_valid = 1'b0;
   logic [VA-1:0]   mem_va = '0;
   logic            intr_take = 1'b0;
   logic            vint_post = 1'b0;
   logic [VW-1:0]   vint_num = '0;
   logic            guest_mode, virt_fault, addr_fault, vint_redirect;
   logic [2:0]      fault_cause;
   logic [OPCW-1:0] fault_opc;
   logic [VW-1:0]   redirect_num;

   int checks = 0;
   int errors = 0;

   // reference state
   bit              e_mode, e_vf, e_af, e_rd, e_pend;
   int              e_cause;
   logic [OPCW-1:0] e_opc;
   logic [VW-1:0]   e_num, e_rnum;

   always #(CLK_PERIOD/2) clk = ~clk;

   gmv_fault_top #(.VA_WIDTH(VA), .OPC_W(OPCW), .VINT_W(VW)) u_dut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_cls(instr_cls),
      .instr_opc(instr_opc), .ret_mode(ret_mode), .sw_mode(sw_mode),
      .mem_valid(mem_valid), .mem_va(mem_va), .intr_take(intr_take),
      .vint_post(vint_post), .vint_num(vint_num), .guest_mode(guest_mode),
      .virt_fault(virt_fault), .addr_fault(addr_fault), .vint_redirect(vint_redirect),
      .fault_cause(fault_cause), .fault_opc(fault_opc), .redirect_num(redirect_num)
   );

   task automatic field(string tag, string name, longint got, longint exp);
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, name, got, exp);
      end
   endtask

   task automatic compare(string tag);
      checks++;
      field(tag, "guest_mode",    guest_mode,    e_mode);
      field(tag, "virt_fault",    virt_fault,    e_vf);
      field(tag, "addr_fault",    addr_fault,    e_af);
      field(tag, "vint_redirect", vint_redirect, e_rd);
      field(tag, "fault_cause",   fault_cause,   e_cause);
      field(tag, "fault_opc",     fault_opc,     e_opc);
      field(tag, "redirect_num",  redirect_num,  e_rnum);
   endtask

   task automatic idle();
      instr_valid = 1'b0; instr_cls = '0; instr_opc = '0;
      ret_mode = 1'b0; sw_mode = 1'b0; mem_valid = 1'b0; mem_va = '0;
      intr_take = 1'b0; vint_post = 1'b0; vint_num = '0;
   endtask

   // behavioural reference: evaluate the sampled inputs, then step one edge
   task automatic tick(string tag);
      bit fault = 0, addr = 0, redir = 0;
      int cause = e_cause;
      if (!intr_take && e_mode) begin
         if (instr_valid) begin
            if (instr_cls == 3'd1 || instr_cls == 3'd3) begin fault = 1; cause = 1; end
            else if (instr_cls == 3'd2) begin fault = 1; cause = 2; end
            else if (instr_cls == 3'd5 && e_pend) begin redir = 1; cause = 4; end
         end
         if (!fault && !redir && mem_valid && mem_va[VA-1]) begin addr = 1; cause = 3; end
      end
      if (fault) e_opc = instr_opc;
      if (redir) e_rnum = e_num;
      e_cause = cause;
      e_vf = fault; e_af = addr; e_rd = redir;
      if (intr_take || fault || addr || redir) e_mode = 0;
      else if (instr_valid && instr_cls == 3'd4) e_mode = sw_mode;
      else if (instr_valid && instr_cls == 3'd3 && !e_mode) e_mode = ret_mode;
      if (vint_post) begin e_pend = 1; e_num = vint_num; end
      else if (redir) e_pend = 0;
      @(posedge clk);
      @(negedge clk);
      compare(tag);
      idle();
   endtask

   task automatic ins(int cls, longint opc, string tag);
      instr_valid = 1'b1; instr_cls = 3'(cls); instr_opc = OPCW'(opc);
      tick(tag);
   endtask

   task automatic enter_guest(string tag);
      instr_valid = 1'b1; instr_cls = 3'd4; sw_mode = 1'b1;
      tick(tag);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      e_mode = 0; e_vf = 0; e_af = 0; e_rd = 0; e_pend = 0;
      e_cause = 0; e_opc = '0; e_num = '0; e_rnum = '0;
      idle();
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      // R12 / R2: host mode, nothing faults
      ins(0, 40'h11, "R12");
      ins(1, 40'h12, "R2");
      ins(2, 40'h13, "R2");
      ins(5, 40'h14, "R2");
      mem_valid = 1; mem_va = '0; mem_va[VA-1] = 1; tick("R2");

      // R9: switch and return in host mode
      enter_guest("R9");
      instr_valid = 1; instr_cls = 3'd4; sw_mode = 0; tick("R9");
      instr_valid = 1; instr_cls = 3'd3; ret_mode = 1; tick("R9");
      instr_valid = 1; instr_cls = 3'd4; sw_mode = 1; tick("R9");
      ins(0, 40'h21, "R12");

      // R3: privileged and return-from-interruption in guest mode
      ins(1, 40'hAB_CDEF_0123, "R3");
      ins(1, 40'h55, "R2");
      enter_guest("R9");
      ins(3, 40'h3333, "R3");

      // R4: hash lookup
      enter_guest("R9");
      ins(2, 40'h4242, "R4");

      // R5 and R6: address check; opcode held across the address exception
      enter_guest("R9");
      mem_valid = 1; mem_va = '1; mem_va[VA-1] = 0; tick("R5");
      mem_valid = 1; mem_va = '0; mem_va[VA-1] = 1; tick("R5");
      tick("R6");
      enter_guest("R9");
      ins(1, 40'h6666, "R6");

      // R7: interruption delivery
      enter_guest("R9");
      intr_take = 1; instr_valid = 1; instr_cls = 3'd1; instr_opc = 40'h7777;
      mem_valid = 1; mem_va[VA-1] = 1; tick("R7");
      intr_take = 1; instr_valid = 1; instr_cls = 3'd4; sw_mode = 1; tick("R7");

      // R10: pending virtual interrupt
      vint_post = 1; vint_num = 8'h5A; tick("R10");
      ins(5, 0, "R10");
      enter_guest("R10");
      ins(5, 0, "R10");
      enter_guest("R10");
      ins(5, 0, "R10");
      vint_post = 1; vint_num = 8'h11; tick("R10");
      vint_post = 1; vint_num = 8'h22; tick("R10");
      enter_guest("R10");
      ins(5, 0, "R10");

      // R11: same-cycle collisions
      enter_guest("R11");
      instr_valid = 1; instr_cls = 3'd1; instr_opc = 40'hB1;
      mem_valid = 1; mem_va = '0; mem_va[VA-1] = 1; tick("R11");
      vint_post = 1; vint_num = 8'h31; tick("R11");
      enter_guest("R11");
      instr_valid = 1; instr_cls = 3'd5; vint_post = 1; vint_num = 8'h32;
      mem_valid = 1; mem_va[VA-1] = 1; tick("R11");
      enter_guest("R11");
      ins(5, 0, "R11");
      enter_guest("R12");
      ins(0, 40'hC0, "R12");

      // R8: long mixed stream
      for (int i = 0; i < 3000; i++) begin
         int r = $urandom_range(0, 99);
         instr_valid = ($urandom_range(0, 3) != 0);
         instr_cls   = 3'($urandom_range(0, 5));
         if (r < 25) begin instr_cls = 3'd4; instr_valid = 1; end
         instr_opc   = {9'($urandom), 32'($urandom)};
         ret_mode    = 1'($urandom);
         sw_mode     = ($urandom_range(0, 3) != 0);
         mem_valid   = 1'($urandom);
         mem_va      = {19'($urandom), 32'($urandom)};
         intr_take   = ($urandom_range(0, 15) == 0);
         vint_post   = ($urandom_range(0, 7) == 0);
         vint_num    = 8'($urandom);
         tick("R8");
      end

      finish_run();
   end

endmodule